// File: doc/BRIEF.md
# DMA Completion and Reset Controller

This block follows a single outstanding DMA transfer from the moment it is accepted to the moment it ends. It also runs the timed reset sequence of the DMA engine. A requester asks to start a transfer and gives its direction (toward the host or toward local memory). The block grants the request, or refuses it while another transfer is still open or while the engine is being reset. Each time the engine reports status (toward-host complete, toward-local complete, toward-local dirty), the block decides whether that status ends the open transfer. It then issues a write-one-to-clear of the exact bits it sampled.

The engine reset can be started by a link reset, by a software request, or by the owning client disappearing while its transfer is still open. The engine reset line is held for a fixed hold time and then released. After a further settle time, the block pulses a strobe that tells the queue registers to reinitialise. Any transfer still open at that point is finished with an error. Both delays are 100 us. They are counted in clock cycles as FREQ_MHZ times HOLD_US.

Top module: `dma_cmpl_rst_ctrl`

## Requirements
- R1: A start request that arrives while a transfer is open or while a reset is in progress gives a one-cycle `start_reject` in the next cycle. It gives no grant and leaves `busy` unchanged.
- R2: A start request that arrives while idle and out of reset gives a one-cycle `start_grant` in the next cycle. `busy` rises in that cycle and the direction (`start_up`=1 toward host) is latched.
- R3: Status is a 3-bit vector: bit 2 dirty, bit 1 toward-local complete, bit 0 toward-host complete. When `stat_valid` is high with bit 2 set while a transfer is open, the next cycle shows `done` and `err` both high and `busy` low, whatever the complete bits are.
- R4: Without the dirty bit, bit 0 ends an open transfer only if it was started toward the host, and bit 1 ends it only if it was started toward local memory. Such an ending gives `done` with `err` low. A complete bit for the other direction, or any status while idle, gives no `done`.
- R5: Every `stat_valid` cycle is followed, one cycle later, by a one-cycle `clr_valid` whose `clr_bits` equal the sampled status bits.
- R6: A link reset or software reset request made while no reset is running raises `in_reset` and `eng_rst` in the next cycle. `eng_rst` then stays high for exactly FREQ_MHZ*HOLD_US cycles.
- R7: After `eng_rst` falls, exactly FREQ_MHZ*HOLD_US cycles pass with `in_reset` still high, and then `reinit` is high for one cycle.
- R8: In the cycle after `reinit`, `in_reset` is low. A transfer that was open at that point ends in that same cycle, with `done` and `err` both high.
- R9: Reset triggers that arrive while a reset is running are ignored. The hold and settle lengths are unchanged.
- R10: `client_gone` while a transfer is open and no reset is running starts the reset sequence exactly as R6 does. `client_gone` while idle has no effect.
- R11: After the synchronous reset `rst`, all outputs are low.
- R12: `done` and `err` are single-cycle pulses. `err` is never high without `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_req | input | 1 | Request to start a transfer |
| start_up | input | 1 | Direction of the request, 1 = toward host |
| stat_valid | input | 1 | Engine status sample is valid this cycle |
| stat_bits | input | 3 | {dirty, toward-local complete, toward-host complete} |
| sw_reset_req | input | 1 | Software request to reset the engine |
| link_reset | input | 1 | Link reset event |
| client_gone | input | 1 | Owning client has gone away |
| start_grant | output | 1 | Start request accepted (pulse) |
| start_reject | output | 1 | Start request refused (pulse) |
| busy | output | 1 | A transfer is open |
| done | output | 1 | Open transfer finished (pulse) |
| err | output | 1 | Finished transfer failed (pulse, with done) |
| clr_valid | output | 1 | Write-one-to-clear strobe to the status register |
| clr_bits | output | 3 | Status bits to clear |
| eng_rst | output | 1 | Engine reset line |
| in_reset | output | 1 | Reset sequence running |
| reinit | output | 1 | Reinitialise the queue registers (pulse) |

## Verification
The hardest situation to reach is a transfer that is still open when the reset sequence finishes, while further triggers and start requests land inside the hold and settle windows. The stimulus gets there by granting a transfer and withholding every completion status. It then fires a link reset and injects both trigger kinds in the middle of the hold phase, then a link reset and a start request in the middle of the settle phase. The hold and settle lengths are counted at the ports, and the forced error completion is observed in the cycle after the reinitialise strobe.

// File: rtl/dma_cmpl_rst_pkg.sv
package dma_cmpl_rst_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE   = 2'd0,
    SEQ_HOLD   = 2'd1,
    SEQ_SETTLE = 2'd2,
    SEQ_REINIT = 2'd3
  } seq_state_t;

  typedef struct packed {
    logic dirty;
    logic dn_cmp;
    logic up_cmp;
  } eng_stat_t;

endpackage

// File: rtl/dma_xfer_tracker.sv
module dma_xfer_tracker
  import dma_cmpl_rst_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      start_req,
  input  logic      start_up,
  input  logic      stat_valid,
  input  eng_stat_t stat,
  input  logic      in_reset,
  input  logic      rst_finish,
  output logic      busy_q,
  output logic      dir_up_q,
  output logic      grant_q,
  output logic      reject_q,
  output logic      done_q,
  output logic      err_q
);

  logic cmpl_hit;

  // a status sample ends the open transfer only for its own direction
  assign cmpl_hit = stat_valid &
                    (stat.dirty | (stat.up_cmp & dir_up_q) | (stat.dn_cmp & ~dir_up_q));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q   <= 1'b0;
      dir_up_q <= 1'b0;
      grant_q  <= 1'b0;
      reject_q <= 1'b0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      grant_q  <= 1'b0;
      reject_q <= 1'b0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
      if (busy_q) begin
        if (rst_finish) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          err_q  <= 1'b1;
        end else if (cmpl_hit) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          err_q  <= stat.dirty;
        end
      end
      if (start_req) begin
        if (busy_q || in_reset) begin
          reject_q <= 1'b1;
        end else begin
          grant_q  <= 1'b1;
          busy_q   <= 1'b1;
          dir_up_q <= start_up;
        end
      end
    end
  end

endmodule

// File: rtl/dma_rst_sequencer.sv
module dma_rst_sequencer
  import dma_cmpl_rst_pkg::*;
#(
  parameter int SETTLE_CYC = 100
) (
  input  logic clk,
  input  logic rst,
  input  logic trigger,
  output logic eng_rst_q,
  output logic reinit_q,
  output logic in_reset
);

  localparam int CNT_W = $clog2(SETTLE_CYC + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SETTLE_CYC - 1);

  seq_state_t       state_q;
  logic [CNT_W-1:0] cnt_q;

  assign in_reset = (state_q != SEQ_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= SEQ_IDLE;
      cnt_q     <= '0;
      eng_rst_q <= 1'b0;
      reinit_q  <= 1'b0;
    end else begin
      case (state_q)
        SEQ_IDLE: begin
          if (trigger) begin
            state_q   <= SEQ_HOLD;
            cnt_q     <= '0;
            eng_rst_q <= 1'b1;
          end
        end
        SEQ_HOLD: begin
          if (cnt_q == LAST) begin
            state_q   <= SEQ_SETTLE;
            cnt_q     <= '0;
            eng_rst_q <= 1'b0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        SEQ_SETTLE: begin
          if (cnt_q == LAST) begin
            state_q  <= SEQ_REINIT;
            reinit_q <= 1'b1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: begin
          state_q  <= SEQ_IDLE;
          reinit_q <= 1'b0;
        end
      endcase
    end
  end

endmodule

// File: rtl/dma_stat_ack.sv
module dma_stat_ack #(
  parameter int STAT_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              stat_valid,
  input  logic [STAT_W-1:0] stat_bits,
  output logic              clr_valid_q,
  output logic [STAT_W-1:0] clr_bits_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      clr_valid_q <= 1'b0;
      clr_bits_q  <= '0;
    end else begin
      clr_valid_q <= stat_valid;
      clr_bits_q  <= stat_valid ? stat_bits : '0;
    end
  end

endmodule

// File: rtl/dma_cmpl_rst_ctrl.sv
module dma_cmpl_rst_ctrl
  import dma_cmpl_rst_pkg::*;
#(
  parameter int FREQ_MHZ = 100,
  parameter int HOLD_US  = 100
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start_req,
  input  logic       start_up,
  input  logic       stat_valid,
  input  logic [2:0] stat_bits,
  input  logic       sw_reset_req,
  input  logic       link_reset,
  input  logic       client_gone,
  output logic       start_grant,
  output logic       start_reject,
  output logic       busy,
  output logic       done,
  output logic       err,
  output logic       clr_valid,
  output logic [2:0] clr_bits,
  output logic       eng_rst,
  output logic       in_reset,
  output logic       reinit
);

  localparam int SETTLE_CYC = FREQ_MHZ * HOLD_US;

  eng_stat_t stat_s;
  logic      busy_s;
  logic      xfer_dir_up;
  logic      rst_fin;
  logic      in_rst_s;
  logic      rst_trig;

  assign stat_s   = eng_stat_t'(stat_bits);
  assign rst_trig = link_reset | sw_reset_req | (client_gone & busy_s);
  assign rst_fin  = reinit;
  assign busy     = busy_s;
  assign in_reset = in_rst_s;

  dma_xfer_tracker u_trk (
    .clk        (clk),
    .rst        (rst),
    .start_req  (start_req),
    .start_up   (start_up),
    .stat_valid (stat_valid),
    .stat       (stat_s),
    .in_reset   (in_rst_s),
    .rst_finish (rst_fin),
    .busy_q     (busy_s),
    .dir_up_q   (xfer_dir_up),
    .grant_q    (start_grant),
    .reject_q   (start_reject),
    .done_q     (done),
    .err_q      (err)
  );

  dma_rst_sequencer #(.SETTLE_CYC(SETTLE_CYC)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .trigger   (rst_trig),
    .eng_rst_q (eng_rst),
    .reinit_q  (reinit),
    .in_reset  (in_rst_s)
  );

  dma_stat_ack #(.STAT_W(3)) u_ack (
    .clk         (clk),
    .rst         (rst),
    .stat_valid  (stat_valid),
    .stat_bits   (stat_bits),
    .clr_valid_q (clr_valid),
    .clr_bits_q  (clr_bits)
  );

endmodule

// File: rtl/dma_cmpl_rst_chk.sv
module dma_cmpl_rst_chk #(
  parameter int SETTLE_CYC = 100
) (
  input logic       clk,
  input logic       rst,
  input logic       start_req,
  input logic       stat_valid,
  input logic [2:0] stat_bits,
  input logic       client_gone,
  input logic       start_grant,
  input logic       start_reject,
  input logic       busy,
  input logic       done,
  input logic       err,
  input logic       clr_valid,
  input logic [2:0] clr_bits,
  input logic       eng_rst,
  input logic       in_reset,
  input logic       reinit,
  input logic       xfer_dir_up
);

  logic [31:0] run_q;
  always_ff @(posedge clk) begin
    if (rst) run_q <= '0;
    else     run_q <= eng_rst ? run_q + 1 : '0;
  end

  assert_refuse_R1: assert property (@(posedge clk) disable iff (rst)
    start_req && (busy || in_reset) |=> start_reject && !start_grant);

  assert_grant_R2: assert property (@(posedge clk) disable iff (rst)
    start_req && !busy && !in_reset |=> start_grant && busy);

  assert_dirty_err_R3: assert property (@(posedge clk) disable iff (rst)
    busy && stat_valid && stat_bits[2] |=> done && err);

  assert_wrong_dir_R4: assert property (@(posedge clk) disable iff (rst)
    busy && stat_valid && !stat_bits[2] && !reinit &&
    (xfer_dir_up ? !stat_bits[0] : !stat_bits[1]) |=> !done);

  assert_writeback_R5: assert property (@(posedge clk) disable iff (rst)
    stat_valid |=> clr_valid && clr_bits == $past(stat_bits));

  assert_hold_len_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(eng_rst) |-> run_q == SETTLE_CYC);

  assert_rst_entry_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(in_reset) |-> eng_rst);

  assert_exit_R8: assert property (@(posedge clk) disable iff (rst)
    reinit |=> !in_reset);

  assert_abort_R8: assert property (@(posedge clk) disable iff (rst)
    reinit && busy |=> done && err);

  assert_gone_R10: assert property (@(posedge clk) disable iff (rst)
    client_gone && busy && !in_reset |=> in_reset);

  assert_pulse_R12: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_err_with_done_R12: assert property (@(posedge clk) disable iff (rst)
    err |-> done);

endmodule

bind dma_cmpl_rst_ctrl dma_cmpl_rst_chk #(.SETTLE_CYC(SETTLE_CYC)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .start_req    (start_req),
  .stat_valid   (stat_valid),
  .stat_bits    (stat_bits),
  .client_gone  (client_gone),
  .start_grant  (start_grant),
  .start_reject (start_reject),
  .busy         (busy),
  .done         (done),
  .err          (err),
  .clr_valid    (clr_valid),
  .clr_bits     (clr_bits),
  .eng_rst      (eng_rst),
  .in_reset     (in_reset),
  .reinit       (reinit),
  .xfer_dir_up  (xfer_dir_up)
);

// File: tb/dma_cmpl_rst_ctrl_tb.sv
module dma_cmpl_rst_ctrl_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int FREQ = 1;
  localparam int HOLD = 100;
  localparam int S = FREQ * HOLD;

  // row: [10]start [9]up [8]stat_valid [7:5]stat {dirty,dn,up}
  //      [4]grant [3]reject [2]done [1]err [0]busy
  localparam int NV = 13;
  localparam logic [10:0] VEC [NV] = '{
    11'b11000010001, // R2 start toward host
    11'b00101000001, // R4 wrong-direction complete ignored
    11'b10000001001, // R1 refused while busy
    11'b00100100100, // R4 matching complete
    11'b00100100000, // R4 status while idle
    11'b10000010001, // R2 start toward local
    11'b00100100001, // R4 toward-host bit ignored
    11'b00101100100, // R4 both bits, own direction ends it
    11'b11000010001, // R2
    11'b00110100110, // R3 dirty with complete bit
    11'b10000010001, // R2
    11'b00110000110, // R3 dirty alone
    11'b00000000000  // R12 pulses gone
  };

  logic clk = 0, rst = 1;
  logic start_req = 0, start_up = 0, stat_valid = 0;
  logic [2:0] stat_bits = '0;
  logic sw_reset_req = 0, link_reset = 0, client_gone = 0;
  logic start_grant, start_reject, busy, done, err, clr_valid, eng_rst, in_reset, reinit;
  logic [2:0] clr_bits;

  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_cmpl_rst_ctrl #(.FREQ_MHZ(FREQ), .HOLD_US(HOLD)) dut_i (
    .clk(clk), .rst(rst), .start_req(start_req), .start_up(start_up),
    .stat_valid(stat_valid), .stat_bits(stat_bits), .sw_reset_req(sw_reset_req),
    .link_reset(link_reset), .client_gone(client_gone), .start_grant(start_grant),
    .start_reject(start_reject), .busy(busy), .done(done), .err(err),
    .clr_valid(clr_valid), .clr_bits(clr_bits), .eng_rst(eng_rst),
    .in_reset(in_reset), .reinit(reinit)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic run_reset(input bit had_xfer, input bit inject);
    int hi, lo;
    check("R6 in_reset/eng_rst raised", {30'd0, in_reset, eng_rst}, 32'h3);
    hi = 0;
    while (eng_rst && hi < 5000) begin
      hi++;
      if (inject && hi == 20) begin link_reset = 1; sw_reset_req = 1; end
      tick();
      link_reset = 0; sw_reset_req = 0;
    end
    check(inject ? "R9 hold length with retrigger" : "R6 hold length", hi, S);
    lo = 0;
    while (!reinit && lo < 5000) begin
      lo++;
      if (inject && lo == 30) begin link_reset = 1; start_req = 1; start_up = 1; end
      tick();
      if (inject && lo == 30) begin
        link_reset = 0; start_req = 0;
        check("R1 start refused in reset", {30'd0, start_reject, start_grant}, 32'h2);
      end
    end
    check(inject ? "R9 settle length with retrigger" : "R7 settle length", lo, S);
    check("R7 still in reset at reinit", {30'd0, in_reset, done}, 32'h2);
    tick();
    check("R8 exit and abort", {28'd0, in_reset, busy, done, err},
          {28'd0, 1'b0, 1'b0, had_xfer, had_xfer});
    tick();
    check("R12 done pulse ends", {30'd0, done, err}, 32'h0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    tick(); tick();
    rst = 0;
    check("R11 reset state",
          {19'd0, start_grant, start_reject, busy, done, err, clr_valid, clr_bits,
           eng_rst, in_reset, reinit}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      start_req  = VEC[i][10];
      start_up   = VEC[i][9];
      stat_valid = VEC[i][8];
      stat_bits  = VEC[i][7:5];
      tick();
      start_req = 0; stat_valid = 0; stat_bits = '0;
      check($sformatf("R1-R4 row %0d outputs", i),
            {27'd0, start_grant, start_reject, done, err, busy}, {27'd0, VEC[i][4:0]});
      check($sformatf("R5 row %0d write-back", i), {28'd0, clr_valid, clr_bits},
            {28'd0, VEC[i][8], VEC[i][7:5]});
    end

    // R6 R7 R8 R9: open transfer aborted by link reset, retriggers injected
    start_req = 1; start_up = 1; tick(); start_req = 0;
    check("R2 grant before reset", {31'd0, busy}, 32'h1);
    link_reset = 1; tick(); link_reset = 0;
    run_reset(1'b1, 1'b1);

    // R6 software request while idle: no done at the end
    sw_reset_req = 1; tick(); sw_reset_req = 0;
    run_reset(1'b0, 1'b0);

    // R10 client leaving while idle has no effect
    client_gone = 1; tick(); client_gone = 0;
    check("R10 idle client_gone ignored", {30'd0, in_reset, eng_rst}, 32'h0);

    // R10 client leaving while transfer open starts reset
    start_req = 1; start_up = 0; tick(); start_req = 0;
    client_gone = 1; tick(); client_gone = 0;
    run_reset(1'b1, 1'b0);

    // R5 status during idle after everything still written back
    stat_valid = 1; stat_bits = 3'b110; tick(); stat_valid = 0; stat_bits = '0;
    check("R5 write-back late", {28'd0, clr_valid, clr_bits}, 32'he);
    check("R4 idle status no done", {31'd0, done}, 32'h0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule